// File: doc/BRIEF.md
# Escalating-Priority Retry Arbiter

This block sits at the home of one shared block that many nodes write often. It decides, one request per cycle, whether a requester may take the block now. It answers every request it accepts with a grant or a negative acknowledgement (NACK). A requester that is refused comes back with a priority one step higher.

The home keeps a single waiting slot. The slot remembers the node ID and priority of the strongest refused request seen so far. When the block is free, only the node named in the slot can win. Every other node keeps getting refused until that node has been served. Because priorities only rise until a grant, a node that keeps losing eventually owns the slot and gets through.

The per-node retry counters sit inside the block, next to the home logic. Each node's demand is a level signal, and the requests travel over a simple request/response handshake. A refused node's retry carries its raised priority. A node keeps asking while its demand input stays high.

Top module: `prio_retry_arbiter`

## Requirements
- R1: After reset, grant and nack are all zero, every node priority is 0, and the waiting slot is empty (pend_valid low).
- R2: Each cycle, the node served is the first node with want high, searching upward with wrap-around from a rotating pointer. The pointer starts at node 0 and moves to the served node plus one. The answer appears on the one-hot grant or nack outputs on the next cycle, and at most one of all these bits is high.
- R3: A request served while blk_busy is high always gets a NACK.
- R4: A request served while blk_busy is low and the slot is empty is granted.
- R5: While blk_busy is low and the slot is valid, a request from the slot's node is granted and the slot becomes empty. A request from any other node gets a NACK.
- R6: On a NACK, the node's priority rises by one. At the 3-bit maximum of 7 it stays at 7.
- R7: On a grant, the node's priority returns to 0, so its next request starts fresh at 0.
- R8: A refused request loads its node ID and the priority it carried into the slot if the slot is empty, or if that priority is strictly higher than the slot's priority. On a tie, or a lower priority, the slot keeps its current entry.
- R9: With all nodes contending continuously and the block alternating busy and free for one pointer round each, no single request is refused more than 8 + NODES times before it is granted.
- R10: A node whose want is low in a cycle gets no grant or NACK for that cycle, and its priority is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| want | input | NODES | Per-node request level |
| blk_busy | input | 1 | High while the shared block cannot be handed out |
| grant | output | NODES | One-hot grant, one cycle after the request is served |
| nack | output | NODES | One-hot refusal, one cycle after the request is served |
| node_prio | output | NODES*PW | Current retry priority of each node, node i in bits [i*PW +: PW] |
| pend_valid | output | 1 | Waiting slot holds an entry |
| pend_node | output | $clog2(NODES) | Node ID held in the waiting slot |
| pend_prio | output | PW | Priority held in the waiting slot |

## Verification
The bench builds the block with 4 nodes and a 3-bit priority. With these values, saturation at 7 is reached within a handful of refusals. Four contenders also make the slot contested often under random demand.

Directed runs cover:
- ties at the slot,
- a lone node being pushed past the priority ceiling,
- the starvation bound under alternating busy and free rounds.

A random phase compares every output, each cycle, against a bench-side reference of the rules.

// File: rtl/nackarb_pkg.sv
// Package: shared definitions for the escalating-priority retry arbiter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package nackarb_pkg;

    // Outcome of one served request
    typedef enum logic [1:0] {
        RESP_NONE  = 2'd0,
        RESP_GRANT = 2'd1,
        RESP_NACK  = 2'd2
    } resp_e;

    // Saturating increment of a priority value of any width up to 8 bits
    function automatic logic [7:0] sat_inc(input logic [7:0] v, input logic [7:0] vmax);
        return (v >= vmax) ? vmax : v + 8'd1;
    endfunction

endpackage

// File: rtl/arb_rr_pick.sv
// Module: arb_rr_pick
// Picks one requesting node per cycle, searching upward with wrap-around from
// a rotating pointer. The pointer moves past the served node.
// Assumes NODES >= 2.
module arb_rr_pick #(
    parameter int NODES = 4,
    localparam int IDW = $clog2(NODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NODES-1:0] want,
    output logic             sel_valid,
    output logic [IDW-1:0]   sel_id
);

    logic [IDW-1:0] ptr_q;

    // First requester at or above the pointer; the lowest offset wins
    always_comb begin
        sel_valid = 1'b0;
        sel_id    = '0;
        for (int k = NODES - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(ptr_q) + k) % NODES;
            if (want[idx]) begin
                sel_valid = 1'b1;
                sel_id    = IDW'(idx);
            end
        end
    end

    // Rotate the pointer to just past the node served
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (sel_valid) begin
            ptr_q <= (sel_id == IDW'(NODES - 1)) ? '0 : sel_id + 1'b1;
        end
    end

endmodule

// File: rtl/arb_req_agent.sv
// Module: arb_req_agent
// Requester-side retry counter for one node. It rises by one on each refusal,
// stops at the all-ones maximum, and clears on a grant.
// Assumes grant_in and nack_in are never high together.
module arb_req_agent #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grant_in,
    input  logic          nack_in,
    output logic [PW-1:0] prio
);

    localparam logic [PW-1:0] PMAX = '1;

    // Escalate on refusal with saturation; restart at zero after a grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio <= '0;
        end else if (grant_in) begin
            prio <= '0;
        end else if (nack_in && prio != PMAX) begin
            prio <= prio + 1'b1;
        end
    end

endmodule

// File: rtl/arb_home_slot.sv
// Module: arb_home_slot
// Home-side decision and the one-entry waiting slot. It grants or refuses the
// selected request, and keeps the strongest refused request in the slot.
// Assumes sel_prio is the priority the selected request carries this cycle.
module arb_home_slot
    import nackarb_pkg::*;
#(
    parameter int NODES = 4,
    parameter int PW    = 3,
    localparam int IDW = $clog2(NODES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_valid,
    input  logic [IDW-1:0] sel_id,
    input  logic [PW-1:0]  sel_prio,
    input  logic           blk_busy,
    output resp_e          resp,
    output logic           pend_valid,
    output logic [IDW-1:0] pend_node,
    output logic [PW-1:0]  pend_prio
);

    logic slot_hit;
    logic may_grant;
    logic take_slot;

    // Decide the outcome for the selected request
    always_comb begin
        slot_hit  = pend_valid && (pend_node == sel_id);
        may_grant = !blk_busy && (!pend_valid || slot_hit);
        take_slot = !pend_valid || (sel_prio > pend_prio);
        if (!sel_valid) begin
            resp = RESP_NONE;
        end else if (may_grant) begin
            resp = RESP_GRANT;
        end else begin
            resp = RESP_NACK;
        end
    end

    // Clear the slot when its owner is granted; load on a stronger refusal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_node  <= '0;
            pend_prio  <= '0;
        end else if (resp == RESP_GRANT && slot_hit) begin
            pend_valid <= 1'b0;
        end else if (resp == RESP_NACK && take_slot) begin
            pend_valid <= 1'b1;
            pend_node  <= sel_id;
            pend_prio  <= sel_prio;
        end
    end

endmodule

// File: rtl/prio_retry_arbiter.sv
// Module: prio_retry_arbiter
// Top level: round-robin request pick, per-node retry counters, the home slot
// and registered one-hot grant/NACK responses.
// Assumes want is a level signal held by each node while it still needs the
// block.
module prio_retry_arbiter
    import nackarb_pkg::*;
#(
    parameter int NODES = 4,
    parameter int PW    = 3,
    localparam int IDW = $clog2(NODES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NODES-1:0]    want,
    input  logic                blk_busy,
    output logic [NODES-1:0]    grant,
    output logic [NODES-1:0]    nack,
    output logic [NODES*PW-1:0] node_prio,
    output logic                pend_valid,
    output logic [IDW-1:0]      pend_node,
    output logic [PW-1:0]       pend_prio
);

    logic           sel_valid;
    logic [IDW-1:0] sel_id;
    logic [PW-1:0]  sel_prio;
    resp_e          resp;

    arb_rr_pick #(.NODES(NODES)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .want      (want),
        .sel_valid (sel_valid),
        .sel_id    (sel_id)
    );

    // Priority carried by the selected request
    always_comb begin
        sel_prio = '0;
        for (int i = 0; i < NODES; i++) begin
            if (sel_id == IDW'(i)) sel_prio = node_prio[i*PW +: PW];
        end
    end

    arb_home_slot #(.NODES(NODES), .PW(PW)) u_home (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_valid  (sel_valid),
        .sel_id     (sel_id),
        .sel_prio   (sel_prio),
        .blk_busy   (blk_busy),
        .resp       (resp),
        .pend_valid (pend_valid),
        .pend_node  (pend_node),
        .pend_prio  (pend_prio)
    );

    for (genvar g = 0; g < NODES; g++) begin : g_agent
        logic hit_me;
        assign hit_me = (sel_id == IDW'(g));
        arb_req_agent #(.PW(PW)) u_agent (
            .clk      (clk),
            .rst_n    (rst_n),
            .grant_in (hit_me && resp == RESP_GRANT),
            .nack_in  (hit_me && resp == RESP_NACK),
            .prio     (node_prio[g*PW +: PW])
        );
    end

    // Register the one-hot response toward the served node
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= '0;
            nack  <= '0;
        end else begin
            grant <= (resp == RESP_GRANT) ? (NODES'(1) << sel_id) : '0;
            nack  <= (resp == RESP_NACK)  ? (NODES'(1) << sel_id) : '0;
        end
    end

endmodule

// File: rtl/prio_retry_chk.sv
// Module: prio_retry_chk
// Checker for prio_retry_arbiter. It relates responses, node priorities and
// the waiting slot across cycles. Attached to the top module through bind.
module prio_retry_chk #(
    parameter int NODES = 4,
    parameter int PW    = 3,
    localparam int IDW = $clog2(NODES)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NODES-1:0]    want,
    input logic                blk_busy,
    input logic [NODES-1:0]    grant,
    input logic [NODES-1:0]    nack,
    input logic [NODES*PW-1:0] node_prio,
    input logic                pend_valid,
    input logic [IDW-1:0]      pend_node,
    input logic [PW-1:0]       pend_prio
);

    localparam logic [PW-1:0] PMAX = '1;

    // R2
    one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant | nack) <= 1);

    // R10
    want_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant | nack) != '0) |-> (((grant | nack) & ~$past(want)) == '0));

    // R3
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(blk_busy) |-> (grant == '0));

    // R5
    slot_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && $past(pend_valid)) |-> (grant[$past(pend_node)] && !pend_valid));

    // R8
    slot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && $past(pend_valid)) |-> (pend_prio >= $past(pend_prio)));

    for (genvar g = 0; g < NODES; g++) begin : g_node
        // R6
        nack_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            nack[g] |-> (node_prio[g*PW +: PW] ==
                (($past(node_prio[g*PW +: PW]) == PMAX) ? PMAX : $past(node_prio[g*PW +: PW]) + 1'b1)));

        // R7
        grant_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[g] |-> (node_prio[g*PW +: PW] == '0));
    end

endmodule

bind prio_retry_arbiter prio_retry_chk #(.NODES(NODES), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .want       (want),
    .blk_busy   (blk_busy),
    .grant      (grant),
    .nack       (nack),
    .node_prio  (node_prio),
    .pend_valid (pend_valid),
    .pend_node  (pend_node),
    .pend_prio  (pend_prio)
);

// File: tb/tb_prio_retry_arbiter.sv
`timescale 1ns/1ps
module tb_prio_retry_arbiter;

    localparam int N    = 4;
    localparam int PW   = 3;
    localparam int IDW  = $clog2(N);
    localparam int PMAX = 7;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N-1:0]      want;
    logic              blk_busy;
    logic [N-1:0]      grant;
    logic [N-1:0]      nack;
    logic [N*PW-1:0]   node_prio;
    logic              pend_valid;
    logic [IDW-1:0]    pend_node;
    logic [PW-1:0]     pend_prio;

    prio_retry_arbiter #(.NODES(N), .PW(PW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .want       (want),
        .blk_busy   (blk_busy),
        .grant      (grant),
        .nack       (nack),
        .node_prio  (node_prio),
        .pend_valid (pend_valid),
        .pend_node  (pend_node),
        .pend_prio  (pend_prio)
    );

    always #2.5 clk = ~clk;

    // Reference state
    int  m_prio [N];
    bit  m_pv;
    int  m_pid, m_pp, m_ptr;
    int  nk [N];
    bit  bound_on;
    int  grants_seen [N];
    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int sat_up(input int v);
        return (v >= PMAX) ? PMAX : v + 1;
    endfunction

    function automatic int pick(input logic [N-1:0] w, input int ptr);
        for (int k = 0; k < N; k++) begin
            if (w[(ptr + k) % N]) return (ptr + k) % N;
        end
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_prio[i] = 0;
            nk[i] = 0;
        end
        m_pv = 0; m_pid = 0; m_pp = 0; m_ptr = 0;
    endtask

    // One cycle: inputs are already driven; predict, clock, compare
    task automatic step();
        int sel;
        logic [N-1:0] eg, en;
        string rtag;
        bit hit, ok;
        eg = '0; en = '0; rtag = "R10";
        sel = pick(want, m_ptr);
        if (sel >= 0) begin
            m_ptr = (sel + 1) % N;
            hit = m_pv && (m_pid == sel);
            ok  = !blk_busy && (!m_pv || hit);
            if (ok) begin
                rtag = m_pv ? "R5" : "R4";
                eg[sel] = 1'b1;
                if (hit) m_pv = 0;
                m_prio[sel] = 0;
            end else begin
                rtag = blk_busy ? "R3" : "R5";
                en[sel] = 1'b1;
                if (!m_pv || m_prio[sel] > m_pp) begin
                    m_pv = 1; m_pid = sel; m_pp = m_prio[sel];
                end
                m_prio[sel] = sat_up(m_prio[sel]);
            end
        end
        @(posedge clk); #1;
        check(grant == eg, rtag, "grant vector", int'(grant), int'(eg));
        check(nack == en, rtag, "nack vector", int'(nack), int'(en));
        for (int i = 0; i < N; i++) begin
            string ptag;
            ptag = en[i] ? "R6" : (eg[i] ? "R7" : "R10");
            check(int'(node_prio[i*PW +: PW]) == m_prio[i], ptag, $sformatf("prio of node %0d", i),
                  int'(node_prio[i*PW +: PW]), m_prio[i]);
            if (en[i]) nk[i]++;
            if (eg[i]) begin
                if (bound_on) begin
                    // R9 refusals per request stay within range plus contenders
                    check(nk[i] <= PMAX + 1 + N, "R9", $sformatf("refusals before grant node %0d", i),
                          nk[i], PMAX + 1 + N);
                    grants_seen[i]++;
                end
                nk[i] = 0;
            end
        end
        check(pend_valid == m_pv, "R8", "slot valid", int'(pend_valid), int'(m_pv));
        if (m_pv) begin
            check(int'(pend_node) == m_pid, "R8", "slot node", int'(pend_node), m_pid);
            check(int'(pend_prio) == m_pp, "R8", "slot prio", int'(pend_prio), m_pp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; want = '0; blk_busy = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_reset();
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1187));
        bound_on = 0;
        for (int i = 0; i < N; i++) grants_seen[i] = 0;

        // R1 reset state
        do_reset();
        check(grant == '0 && nack == '0, "R1", "responses after reset", int'(grant | nack), 0);
        check(node_prio == '0, "R1", "priorities after reset", int'(node_prio), 0);
        check(pend_valid == 1'b0, "R1", "slot after reset", int'(pend_valid), 0);

        // R10 idle: no demand, nothing happens
        repeat (3) step();

        // R4 free block, empty slot: immediate grant
        want = 4'b0100; step();
        check(grant == 4'b0100, "R4", "lone grant", int'(grant), 4);
        want = '0; step();

        // R6 saturation: lone node pushed past the ceiling
        do_reset();
        want = 4'b0001; blk_busy = 1'b1;
        repeat (10) step();
        check(int'(node_prio[0 +: PW]) == PMAX, "R6", "saturated prio", int'(node_prio[0 +: PW]), PMAX);
        check(int'(pend_prio) == PMAX, "R8", "slot at ceiling", int'(pend_prio), PMAX);
        blk_busy = 1'b0; step();
        check(grant == 4'b0001, "R7", "ceiling node granted", int'(grant), 1);
        check(int'(node_prio[0 +: PW]) == 0, "R7", "prio cleared", int'(node_prio[0 +: PW]), 0);

        // R8 ties keep the entry; strictly higher replaces it
        do_reset();
        blk_busy = 1'b1;
        want = 4'b0010; step();
        want = 4'b0100; step();
        check(int'(pend_node) == 1, "R8", "tie keeps holder", int'(pend_node), 1);
        step();
        check(int'(pend_node) == 2, "R8", "higher replaces holder", int'(pend_node), 2);
        // R5 free block: the non-holder is refused, the holder wins
        blk_busy = 1'b0;
        want = 4'b0010; step();
        check(nack == 4'b0010, "R5", "non-holder refused", int'(nack), 2);
        want = 4'b0100; step();
        check(grant == 4'b0100 && !pend_valid, "R5", "holder granted, slot freed",
              int'(grant), 4);
        want = '0; step();

        // R9 starvation bound: full contention, busy and free rounds alternate
        do_reset();
        bound_on = 1;
        want = '1;
        for (int r = 0; r < 60; r++) begin
            blk_busy = (r % 2 == 0);
            repeat (N) step();
        end
        bound_on = 0;
        for (int i = 0; i < N; i++)
            check(grants_seen[i] > 0, "R9", $sformatf("node %0d made progress", i), grants_seen[i], 1);

        // R2 random phase against the reference
        do_reset();
        for (int c = 0; c < 4000; c++) begin
            want     = N'($urandom);
            blk_busy = ($urandom % 100) < 45;
            step();
        end
        want = '0; blk_busy = 1'b0;
        step();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule